// File: doc/BRIEF.md
# Pin Interrupt Controller

This block turns activity on eight external pins into interrupt requests for a small processor. Every pin is brought into the clock domain through a two-stage synchronizer. A two-bit sense field then picks what counts as activity on that pin: a low level, any change, a falling edge or a rising edge. In the three edge modes a detected event latches a sticky pending bit. In low-level mode the pending bit is forced to zero, and the synchronized pin level feeds the request directly. A pin's activity is seen whatever the direction of the pad, so firmware that drives a pin can raise its own interrupt.

A pin asks for service when its enable bit is set and it is either pending or low in level mode. The global interrupt enable input gates all pins together. Among the pins that ask for service, the lowest-numbered one wins. Its number appears on `irq_idx` together with `irq_req`. When the processor takes the vector it pulses `irq_ack`, and this clears the pending bit of the pin shown on `irq_idx`. Software can also clear pending bits by writing ones to them. Enables, pending bits and sense fields sit on a small register bus with a write strobe and a combinational read port.

Top module: `pinirq_ctrl`

## Requirements
- R1: After reset the enable, pending and both sense registers read zero, `irq_req` is low and `irq_idx` is 0.
- R2: The sense code of pin n sits at bits [2(n%4)+1:2(n%4)] of sense register 0 (pins 0-3) or sense register 1 (pins 4-7). In the edge modes the pending bit is set whatever the enable and the global enable hold. 01 sets it on any change, 10 on a falling edge and 11 on a rising edge.
- R3: A write to the pending register clears each bit written as one. Bits written as zero keep their value.
- R4: With sense code 00 the pin's pending bit reads zero, including a bit that was set before the switch to this mode. The pin requests while its synchronized level is low and stops as soon as the level goes high again, with nothing latched.
- R5: `irq_req` is high only when `gie` is high and at least one enabled pin is pending or is low in level mode.
- R6: When several pins request together, `irq_idx` gives the lowest-numbered one. It reads 0 when there is no request.
- R7: `irq_ack` sampled high while `irq_req` is high clears the pending bit of the pin named by `irq_idx` on that edge.
- R8: If an edge event on a pin reaches the pending logic on the same clock edge as a write-one-to-clear or an acknowledge for that pin, the bit ends up set.
- R9: Register addresses: 0 is the enable mask, 1 is the pending flags, 2 is sense register 0 and 3 is sense register 1. The enable and sense registers read back what was written.
- R10: A pin change present before clock edge k sets its pending bit on edge k+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | External interrupt pins, asynchronous |
| gie | input | 1 | Global interrupt enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from bus_addr |
| irq_req | output | 1 | Interrupt request |
| irq_idx | output | 3 | Number of the winning pin |
| irq_ack | input | 1 | Vector taken; clears the winner's pending bit |

## Verification
The hardest case to reach is a set and a clear of the same pending bit on one clock edge. An edge only reaches the pending logic two clocks after the pin moves, so a clear sent at the same time as the pin change misses it. The stimulus first sets the bit, then toggles the pin on a falling clock edge. Exactly two clocks later it raises the clear write or the acknowledge, and it then checks that the bit is still set. The same latency is also checked on its own: the pending bit must be clear one clock early and set on the expected edge.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    localparam int unsigned REG_AW = 2;

    localparam logic [REG_AW-1:0] A_ENABLE  = 2'd0;
    localparam logic [REG_AW-1:0] A_PENDING = 2'd1;
    localparam logic [REG_AW-1:0] A_MODE0   = 2'd2;

endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prev_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o  = st_q.s2;
    assign prev_o = st_q.prev;

    // prev must trail the synchronized level by one clock
    AST_PREV_TRAILS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> prev_o == $past(lvl_o)); // R10

endmodule

// File: rtl/pinirq_sense.sv
module pinirq_sense
    import pinirq_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic [2*N-1:0] mode_i,
    input  logic [N-1:0]   lvl_i,
    input  logic [N-1:0]   prev_i,
    output logic [N-1:0]   evt_o,
    output logic [N-1:0]   low_o
);

    for (genvar i = 0; i < N; i++) begin : g_pin
        sense_e m;
        assign m = sense_e'(mode_i[2*i +: 2]);

        always_comb begin
            evt_o[i] = 1'b0;
            low_o[i] = 1'b0;
            unique case (m)
                SENSE_LOW:  low_o[i] = ~lvl_i[i];
                SENSE_ANY:  evt_o[i] = lvl_i[i] ^ prev_i[i];
                SENSE_FALL: evt_o[i] = prev_i[i] & ~lvl_i[i];
                SENSE_RISE: evt_o[i] = lvl_i[i] & ~prev_i[i];
                default:    evt_o[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/pinirq_prio.sv
module pinirq_prio #(
    parameter int unsigned N  = 8,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    output logic          valid_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
    end

    assign valid_o = |req_i;

    AST_WINNER_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> req_i[idx_o]); // R6

    AST_NOTHING_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((req_i & ((N'(1) << idx_o) - N'(1))) == '0)); // R6

    AST_IDLE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> idx_o == '0); // R6

endmodule

// File: rtl/pinirq_ctrl.sv
module pinirq_ctrl
    import pinirq_pkg::*;
#(
    parameter int unsigned NPIN = 8,
    localparam int unsigned DW    = NPIN,
    localparam int unsigned MW    = 2 * NPIN,
    localparam int unsigned NMREG = MW / DW,
    localparam int unsigned IW    = (NPIN > 1) ? $clog2(NPIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   pin_i,
    input  logic              gie,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq_req,
    output logic [IW-1:0]     irq_idx,
    input  logic              irq_ack
);

    typedef struct packed {
        logic [NPIN-1:0] en;
        logic [NPIN-1:0] pend;
        logic [MW-1:0]   mode;
    } regs_t;

    regs_t r_d, r_q;

    logic [NPIN-1:0] lvl, prev, evt, low, want;

    pinirq_sync #(.W(NPIN)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .lvl_o  (lvl),
        .prev_o (prev)
    );

    pinirq_sense #(.N(NPIN)) i_sense (
        .mode_i (r_q.mode),
        .lvl_i  (lvl),
        .prev_i (prev),
        .evt_o  (evt),
        .low_o  (low)
    );

    assign want = r_q.en & (r_q.pend | low) & {NPIN{gie}};

    pinirq_prio #(.N(NPIN)) i_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (want),
        .valid_o (irq_req),
        .idx_o   (irq_idx)
    );

    // next-state: bus write, then acknowledge, then events (set wins), then level forcing
    always_comb begin
        r_d = r_q;
        if (bus_we) begin
            if (bus_addr == A_ENABLE)  r_d.en   = bus_wdata;
            if (bus_addr == A_PENDING) r_d.pend = r_q.pend & ~bus_wdata;
            for (int k = 0; k < NMREG; k++) begin
                if (bus_addr == REG_AW'(int'(A_MODE0) + k)) r_d.mode[k*DW +: DW] = bus_wdata;
            end
        end
        if (irq_ack && irq_req) r_d.pend[irq_idx] = 1'b0;
        r_d.pend = r_d.pend | evt;
        for (int i = 0; i < NPIN; i++) begin
            if (sense_e'(r_q.mode[2*i +: 2]) == SENSE_LOW) r_d.pend[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_ENABLE)  bus_rdata = r_q.en;
        if (bus_addr == A_PENDING) bus_rdata = r_q.pend;
        for (int k = 0; k < NMREG; k++) begin
            if (bus_addr == REG_AW'(int'(A_MODE0) + k)) bus_rdata = r_q.mode[k*DW +: DW];
        end
    end

    AST_NO_REQ_WITHOUT_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq_req); // R5

    for (genvar i = 0; i < NPIN; i++) begin : g_chk
        AST_LEVEL_FLAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (sense_e'(r_q.mode[2*i +: 2]) == SENSE_LOW) |=> !r_q.pend[i]); // R4

        AST_SET_OVER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> r_q.pend[i]); // R8

        AST_FLAG_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(r_q.pend[i]) |-> $past(evt[i])); // R2

        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_ack && irq_req && irq_idx == IW'(i) && !evt[i]) |=> !r_q.pend[i]); // R7

        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == A_PENDING && bus_wdata[i] && !evt[i]) |=> !r_q.pend[i]); // R3
    end

endmodule

// File: tb/test_pinirq_ctrl.sv
`timescale 1ns/1ps
module test_pinirq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pins = 8'h00;
    logic       gie = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_req;
    logic [2:0] irq_idx;
    logic       irq_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pinirq_ctrl i_pinirq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pins),
        .gie       (gie),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req),
        .irq_idx   (irq_idx),
        .irq_ack   (irq_ack)
    );

    typedef struct packed {
        logic [7:0] slo;
        logic [7:0] shi;
        logic [7:0] en;
        logic       g;
        logic [7:0] pre;
        logic [7:0] post;
        logic [7:0] eflag;
        logic       ereq;
        logic [2:0] eidx;
    } vec_t;

    // sense codes: 00 low, 01 any, 10 fall, 11 rise; 0xFF all rise, 0xAA all fall, 0x55 all any
    localparam vec_t VECS [8] = '{
        '{8'hFF, 8'hFF, 8'hFF, 1'b1, 8'h00, 8'h05, 8'h05, 1'b1, 3'd0},
        '{8'hAA, 8'hAA, 8'hF0, 1'b1, 8'hFF, 8'h0F, 8'hF0, 1'b1, 3'd4},
        '{8'h55, 8'h55, 8'h80, 1'b1, 8'h0F, 8'hF0, 8'hFF, 1'b1, 3'd7},
        '{8'hFF, 8'hFF, 8'h00, 1'b1, 8'h00, 8'h22, 8'h22, 1'b0, 3'd0},
        '{8'hFF, 8'hFF, 8'hFF, 1'b0, 8'h00, 8'h40, 8'h40, 1'b0, 3'd0},
        '{8'hAA, 8'hAA, 8'hFF, 1'b1, 8'h00, 8'h18, 8'h00, 1'b0, 3'd0},
        '{8'h00, 8'h00, 8'h08, 1'b1, 8'hFF, 8'hF7, 8'h00, 1'b1, 3'd3},
        '{8'hFF, 8'hAA, 8'hFC, 1'b1, 8'hF0, 8'h0F, 8'hFF, 1'b1, 3'd2}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        wait_n(3);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk($sformatf("R1 reg %0d after reset", a), d, 8'h00);
        end
        chk("R1 irq_req after reset", {7'd0, irq_req}, 8'h00);
        chk("R1 irq_idx after reset", {5'd0, irq_idx}, 8'h00);

        // R9 readback
        wr(2'd0, 8'hA5); rd(2'd0, d); chk("R9 enable readback", d, 8'hA5);
        wr(2'd2, 8'h1B); rd(2'd2, d); chk("R9 sense0 readback", d, 8'h1B);
        wr(2'd3, 8'hE4); rd(2'd3, d); chk("R9 sense1 readback", d, 8'hE4);

        // vector table: R2 R5 R6 R4
        for (int v = 0; v < 8; v++) begin
            wr(2'd0, VECS[v].en);
            wr(2'd2, VECS[v].slo);
            wr(2'd3, VECS[v].shi);
            @(negedge clk);
            gie = VECS[v].g;
            pins = VECS[v].pre;
            wait_n(4);
            wr(2'd1, 8'hFF);
            pins = VECS[v].post;
            wait_n(4);
            rd(2'd1, d);
            chk($sformatf("R2 vector %0d flags", v), d, VECS[v].eflag);
            chk($sformatf("R5 vector %0d irq_req", v), {7'd0, irq_req}, {7'd0, VECS[v].ereq});
            chk($sformatf("R6 vector %0d irq_idx", v), {5'd0, irq_idx}, {5'd0, VECS[v].eidx});
        end

        // R10 latency, rising mode
        wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
        @(negedge clk); pins = 8'h00; gie = 1'b0;
        wait_n(4);
        wr(2'd1, 8'hFF);
        bus_addr = 2'd1;
        pins = 8'h01;                    // before edge k
        @(negedge clk);                  // after k
        @(negedge clk);                  // after k+1
        chk("R10 flag still clear after k+1", bus_rdata, 8'h00);
        @(negedge clk);                  // after k+2
        chk("R10 flag set after k+2", bus_rdata, 8'h01);

        // R3 write-one-to-clear
        pins = 8'h0F;
        wait_n(4);
        rd(2'd1, d); chk("R3 flags before clear", d, 8'h0F);
        wr(2'd1, 8'h00); rd(2'd1, d); chk("R3 zero write keeps flags", d, 8'h0F);
        wr(2'd1, 8'h05); rd(2'd1, d); chk("R3 one bits cleared", d, 8'h0A);

        // R7 acknowledge and R6 next winner
        wr(2'd0, 8'hFF);
        @(negedge clk); gie = 1'b1;
        #1 chk("R6 winner before ack", {5'd0, irq_idx}, 8'h01);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        rd(2'd1, d); chk("R7 ack clears winner flag", d, 8'h08);
        chk("R6 next winner after ack", {5'd0, irq_idx}, 8'h03);

        // R8 set beats software clear
        wr(2'd2, 8'h55); wr(2'd3, 8'h55);
        wr(2'd1, 8'hFF);
        @(negedge clk); pins = 8'h0E;
        wait_n(4);
        rd(2'd1, d); chk("R2 any-change sets flag", d, 8'h01);
        @(negedge clk); pins = 8'h0F;    // before edge k
        @(negedge clk);                  // after k
        @(negedge clk);                  // after k+1
        bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h01;
        @(negedge clk); bus_we = 1'b0;   // write met event on k+2
        rd(2'd1, d); chk("R8 event beats write-one-to-clear", d, 8'h01);

        // R8 set beats acknowledge
        wr(2'd0, 8'h01);
        @(negedge clk); pins = 8'h0E;
        @(negedge clk);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        rd(2'd1, d); chk("R8 event beats acknowledge", d, 8'h01);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        rd(2'd1, d); chk("R7 plain ack clears flag", d, 8'h00);

        // R4 level mode
        @(negedge clk); pins = 8'hFF;
        wait_n(4);
        rd(2'd1, d); chk("R2 flag set before level switch", d, 8'hF1);
        wr(2'd2, 8'h00); wr(2'd3, 8'h00);
        rd(2'd1, d); chk("R4 level mode zeroes flags", d, 8'h00);
        chk("R4 no request with pin high", {7'd0, irq_req}, 8'h00);
        pins = 8'hFE;
        wait_n(3);
        chk("R4 low level requests", {7'd0, irq_req}, 8'h01);
        chk("R4 low level index", {5'd0, irq_idx}, 8'h00);
        rd(2'd1, d); chk("R4 flag stays zero while low", d, 8'h00);
        @(negedge clk); gie = 1'b0;
        #1 chk("R5 gie low masks request", {7'd0, irq_req}, 8'h00);
        @(negedge clk); gie = 1'b1; pins = 8'hFF;
        wait_n(3);
        chk("R4 request not latched", {7'd0, irq_req}, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule